// File: doc/BRIEF.md
# Triggered Pulse Generator

This peripheral sits on an 8-bit processor bus and produces one delayed output pulse each time a hardware trigger input rises. Software programs a 16-bit delay, a 16-bit width, the counting timebase and an interrupt source. It then sets the enable bit. From there on, hardware alone starts each pulse. Software never fires a pulse directly.

The trigger pin is asynchronous and passes through a two-stage synchroniser before its rising edge is taken. Delay and width are both counted in ticks of the selected timebase. That timebase is either a free-running microsecond tick or an external clock enable, and either one arrives as a one-cycle synchronous strobe. The interrupt line pulses for one clock on the chosen event. That event is the accepted trigger, the leading edge of the output, or its trailing edge.

Top module: `trig_pulse_gen`

## Requirements
- R1: The register map is as follows. Address 0 holds the delay low byte, address 1 the delay high byte, address 2 the width low byte and address 3 the width high byte. Address 4 is control: bit 0 enable, bit 1 timebase select (1 = external clock enable, 0 = microsecond tick), bits 3:2 interrupt source (0 trigger, 1 output rise, 2 output fall, 3 none). Address 5 is read-only status: bit 0 busy, bit 1 output level. Written values read back, and undefined bits and addresses read 0.
- R2: After reset all registers read 0, the output and the interrupt are low, and the block is idle.
- R3: A trigger rising edge is accepted on the third clock edge after the pin rises, because of the two synchroniser stages. On acceptance the block becomes busy.
- R4: With delay D, the output rises on the (D+1)-th selected tick after acceptance. D = 0 gives a rise on the first tick.
- R5: With width W > 0, the output stays high for exactly W ticks. With W = 0 no pulse appears, and the block returns to idle on the (D+1)-th tick.
- R6: Only the timebase chosen by the control register advances the counters. The other tick input has no effect.
- R7: A trigger edge that arrives while busy is discarded. The running sequence continues unchanged.
- R8: With enable clear, triggers are not accepted and the block stays idle.
- R9: The interrupt is a one-clock pulse. For source 0 it appears in the first busy cycle. For source 1 it appears in the first cycle the output is high. For source 2 it appears in the first cycle after the output falls. Source 3, and the rise and fall sources when W = 0, never raise it.
- R10: Status busy is high from acceptance until the sequence ends, and the output is never high while not busy.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| usec_tick | input | 1 | Internal microsecond strobe |
| ext_ce | input | 1 | External clock enable, already synchronous |
| trig_in | input | 1 | Asynchronous trigger input |
| pulse_out | output | 1 | Generated pulse |
| irq | output | 1 | One-cycle interrupt pulse |

## Verification
The pin rises before clock edge 1, so acceptance lands on edge 3. With the tick on every P-th edge, the rise is due on edge 3+P·(D+1) and the fall on edge 3+P·(D+1+W). Busy runs from edge 3 up to the later of those two edges, and the interrupt is due on edge 3, the rise edge or the fall edge, depending on the source. The bench sweeps delay, width, source, timebase and tick period. It samples output, interrupt and status at the falling edge after every rising edge, and compares each sample against these formulas. Additional runs cover the high register bytes, a retrigger during the pulse and a disabled block.

// File: rtl/tpg_pkg.sv
package tpg_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_DELAY = 2'd1,
        ST_PULSE = 2'd2
    } seq_state_e;

    typedef enum logic [1:0] {
        SRC_TRIG = 2'd0,
        SRC_RISE = 2'd1,
        SRC_FALL = 2'd2,
        SRC_NONE = 2'd3
    } irq_src_e;

    // control byte: [3:2] source, [1] timebase select, [0] enable
    typedef struct packed {
        irq_src_e src;
        logic     ext_sel;
        logic     enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

endpackage

// File: rtl/tpg_sync_edge.sv
module tpg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise
);
    // STAGES synchroniser flops plus one history flop
    logic [STAGES:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

endmodule

// File: rtl/tpg_regs.sv
module tpg_regs
    import tpg_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int ADDR_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              level,
    output logic [7:0]        rdata,
    output logic [CNT_W-1:0]  dly,
    output logic [CNT_W-1:0]  wid,
    output ctrl_t             ctrl
);
    localparam int NB     = CNT_W / 8;
    localparam int A_WID  = NB;
    localparam int A_CTRL = 2 * NB;
    localparam int A_STAT = 2 * NB + 1;

    typedef struct packed {
        logic [CNT_W-1:0] dly;
        logic [CNT_W-1:0] wid;
        ctrl_t            ctrl;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr) begin
            for (int i = 0; i < NB; i++) begin
                if (addr == ADDR_W'(i))         r_d.dly[8*i +: 8] = wdata;
                if (addr == ADDR_W'(A_WID + i)) r_d.wid[8*i +: 8] = wdata;
            end
            if (addr == ADDR_W'(A_CTRL)) r_d.ctrl = ctrl_t'(wdata[CTRL_W-1:0]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NB; i++) begin
            if (addr == ADDR_W'(i))         rdata = r_q.dly[8*i +: 8];
            if (addr == ADDR_W'(A_WID + i)) rdata = r_q.wid[8*i +: 8];
        end
        if (addr == ADDR_W'(A_CTRL)) rdata[CTRL_W-1:0] = r_q.ctrl;
        if (addr == ADDR_W'(A_STAT)) rdata[1:0] = {level, busy};
    end

    assign dly  = r_q.dly;
    assign wid  = r_q.wid;
    assign ctrl = r_q.ctrl;

endmodule

// File: rtl/tpg_seq.sv
module tpg_seq
    import tpg_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             trig_rise,
    input  logic             tick,
    input  irq_src_e         src,
    input  logic [CNT_W-1:0] dly,
    input  logic [CNT_W-1:0] wid,
    output logic             pulse_out,
    output logic             busy,
    output logic             irq
);
    typedef struct packed {
        seq_state_e       state;
        logic [CNT_W-1:0] cnt;
        logic             irq;
    } seq_t;

    seq_t s_d, s_q;
    logic ev_trig, ev_rise, ev_fall;

    always_comb begin
        s_d     = s_q;
        ev_trig = 1'b0;
        ev_rise = 1'b0;
        ev_fall = 1'b0;
        unique case (s_q.state)
            ST_IDLE: begin
                if (enable && trig_rise) begin
                    s_d.state = ST_DELAY;
                    s_d.cnt   = dly;
                    ev_trig   = 1'b1;
                end
            end
            ST_DELAY: begin
                if (tick) begin
                    if (s_q.cnt == '0) begin
                        if (wid == '0) begin
                            s_d.state = ST_IDLE;
                        end else begin
                            s_d.state = ST_PULSE;
                            s_d.cnt   = wid - CNT_W'(1);
                            ev_rise   = 1'b1;
                        end
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            ST_PULSE: begin
                if (tick) begin
                    if (s_q.cnt == '0) begin
                        s_d.state = ST_IDLE;
                        ev_fall   = 1'b1;
                    end else begin
                        s_d.cnt = s_q.cnt - CNT_W'(1);
                    end
                end
            end
            default: s_d.state = ST_IDLE;
        endcase
        unique case (src)
            SRC_TRIG: s_d.irq = ev_trig;
            SRC_RISE: s_d.irq = ev_rise;
            SRC_FALL: s_d.irq = ev_fall;
            default:  s_d.irq = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{state: ST_IDLE, cnt: '0, irq: 1'b0};
        else        s_q <= s_d;
    end

    assign pulse_out = (s_q.state == ST_PULSE);
    assign busy      = (s_q.state != ST_IDLE);
    assign irq       = s_q.irq;

endmodule

// File: rtl/trig_pulse_gen.sv
module trig_pulse_gen
    import tpg_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int ADDR_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    input  logic              usec_tick,
    input  logic              ext_ce,
    input  logic              trig_in,
    output logic              pulse_out,
    output logic              irq
);
    logic [CNT_W-1:0] dly_s, wid_s;
    ctrl_t            ctrl_s;
    logic             trig_rise_s, tick_s, busy_s, enable_s;

    tpg_sync_edge #(.STAGES(SYNC_STAGES)) sync_i (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (trig_in),
        .rise (trig_rise_s)
    );

    tpg_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) regs_i (
        .clk  (clk),
        .rst_n(rst_n),
        .addr (bus_addr),
        .wr   (bus_wr),
        .wdata(bus_wdata),
        .busy (busy_s),
        .level(pulse_out),
        .rdata(bus_rdata),
        .dly  (dly_s),
        .wid  (wid_s),
        .ctrl (ctrl_s)
    );

    assign tick_s   = ctrl_s.ext_sel ? ext_ce : usec_tick;
    assign enable_s = ctrl_s.enable;

    tpg_seq #(.CNT_W(CNT_W)) seq_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .enable   (enable_s),
        .trig_rise(trig_rise_s),
        .tick     (tick_s),
        .src      (ctrl_s.src),
        .dly      (dly_s),
        .wid      (wid_s),
        .pulse_out(pulse_out),
        .busy     (busy_s),
        .irq      (irq)
    );

endmodule

// File: rtl/tpg_chk.sv
module tpg_chk (
    input logic clk,
    input logic rst_n,
    input logic trig_rise,
    input logic enable,
    input logic tick,
    input logic busy,
    input logic pulse_out,
    input logic irq
);
    AST_IRQ_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);  // R9
    AST_OUT_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_out |-> busy);  // R10
    AST_OUT_HOLDS_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(pulse_out));  // R6
    AST_START_NEEDS_TRIGGER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(trig_rise && enable));  // R3
    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !enable) |=> !busy);  // R8
    AST_RISE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pulse_out) |-> $past(busy));  // R4
    AST_RETRIGGER_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !tick) |=> $stable(busy));  // R7
endmodule

bind trig_pulse_gen tpg_chk chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .trig_rise(trig_rise_s),
    .enable   (enable_s),
    .tick     (tick_s),
    .busy     (busy_s),
    .pulse_out(pulse_out),
    .irq      (irq)
);

// File: tb/trig_pulse_gen_tb_top.sv
module trig_pulse_gen_tb_top;

    localparam int CLK_NS = 20;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] bus_addr = '0;
    logic       bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       usec_tick = 1'b0;
    logic       ext_ce = 1'b0;
    logic       trig_in = 1'b0;
    logic       pulse_out;
    logic       irq;

    int n_chk  = 0;
    int n_fail = 0;

    always #(CLK_NS/2) clk = ~clk;

    trig_pulse_gen dut_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_addr (bus_addr),
        .bus_wr   (bus_wr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .usec_tick(usec_tick),
        .ext_ce   (ext_ce),
        .trig_in  (trig_in),
        .pulse_out(pulse_out),
        .irq      (irq)
    );

    task automatic chk(input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic wr_reg(input int a, input int d);
        @(negedge clk);
        bus_addr  = 3'(a);
        bus_wdata = 8'(d);
        bus_wr    = 1'b1;
        @(posedge clk);
        @(negedge clk);
        bus_wr    = 1'b0;
    endtask

    task automatic rd_chk(input int a, input int exp, input string what);
        @(negedge clk);
        bus_addr = 3'(a);
        #1;
        chk(what, int'(bus_rdata), exp);
    endtask

    function automatic bit tick_at(input int j, input int p);
        return (j % p) == (3 % p);
    endfunction

    // trigger raised before edge 1; acceptance on edge 3
    task automatic run_seq(input int d, input int w, input int src, input int sel,
                           input int p, input bit retrig, input string tag);
        int r_e, f_e, n, end_busy;
        bit tk;
        wr_reg(0, d & 8'hFF);
        wr_reg(1, (d >> 8) & 8'hFF);
        wr_reg(2, w & 8'hFF);
        wr_reg(3, (w >> 8) & 8'hFF);
        wr_reg(4, (src << 2) | (sel << 1) | 1);
        r_e      = 3 + p * (d + 1);
        f_e      = 3 + p * (d + 1 + w);
        end_busy = (w > 0) ? f_e : r_e;
        n        = end_busy + 3;
        @(negedge clk);
        bus_addr  = 3'd5;
        trig_in   = 1'b1;
        tk        = tick_at(1, p);
        usec_tick = sel ? ~tk : tk;
        ext_ce    = sel ? tk : ~tk;
        for (int j = 1; j <= n; j++) begin
            bit e_out, e_busy, e_irq;
            @(posedge clk);
            @(negedge clk);
            e_busy = (j >= 3) && (j < end_busy);
            e_out  = (w > 0) && (j >= r_e) && (j < f_e);
            case (src)
                0: e_irq = (j == 3);
                1: e_irq = (w > 0) && (j == r_e);
                2: e_irq = (w > 0) && (j == f_e);
                default: e_irq = 1'b0;
            endcase
            chk($sformatf("R4 R5 %s out d=%0d w=%0d p=%0d sel=%0d j=%0d", tag, d, w, p, sel, j),
                int'(pulse_out), int'(e_out));
            chk($sformatf("R10 R3 %s busy d=%0d w=%0d p=%0d j=%0d", tag, d, w, p, j),
                int'(bus_rdata[0]), int'(e_busy));
            chk($sformatf("R10 %s level d=%0d w=%0d j=%0d", tag, d, w, j),
                int'(bus_rdata[1]), int'(e_out));
            chk($sformatf("R9 %s irq src=%0d d=%0d w=%0d p=%0d j=%0d", tag, src, d, w, p, j),
                int'(irq), int'(e_irq));
            trig_in   = (j + 1 <= 2) || (retrig && (j + 1 >= 6) && (j + 1 <= 8));
            tk        = tick_at(j + 1, p);
            usec_tick = sel ? ~tk : tk;
            ext_ce    = sel ? tk : ~tk;
        end
        trig_in   = 1'b0;
        usec_tick = 1'b0;
        ext_ce    = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R2: reset state
        chk("R2 out after reset", int'(pulse_out), 0);
        chk("R2 irq after reset", int'(irq), 0);
        for (int a = 0; a < 8; a++) rd_chk(a, 0, $sformatf("R2 reg %0d after reset", a));

        // R1: read-back and masking
        wr_reg(0, 8'h5A);
        wr_reg(1, 8'hA5);
        wr_reg(2, 8'h3C);
        wr_reg(3, 8'hC3);
        wr_reg(4, 8'hFE);
        wr_reg(5, 8'hFF);
        rd_chk(0, 8'h5A, "R1 delay low");
        rd_chk(1, 8'hA5, "R1 delay high");
        rd_chk(2, 8'h3C, "R1 width low");
        rd_chk(3, 8'hC3, "R1 width high");
        rd_chk(4, 8'h0E, "R1 control masked");
        rd_chk(5, 8'h00, "R1 status read-only");
        rd_chk(6, 8'h00, "R1 unused address");
        rd_chk(7, 8'h00, "R1 unused address");

        // R8: disabled block ignores a trigger (control 0x00: src trigger, enable clear)
        wr_reg(0, 0); wr_reg(1, 0); wr_reg(2, 1); wr_reg(3, 0);
        wr_reg(4, 8'h00);
        @(negedge clk);
        bus_addr  = 3'd5;
        usec_tick = 1'b1;
        trig_in   = 1'b1;
        for (int j = 1; j <= 10; j++) begin
            @(posedge clk);
            @(negedge clk);
            chk($sformatf("R8 disabled busy j=%0d", j), int'(bus_rdata[0]), 0);
            chk($sformatf("R8 disabled out j=%0d", j), int'(pulse_out), 0);
            chk($sformatf("R8 disabled irq j=%0d", j), int'(irq), 0);
            if (j == 3) trig_in = 1'b0;
        end
        usec_tick = 1'b0;
        repeat (4) @(negedge clk);

        // R4 R5 R6 R9 sweep: delay, width, source, timebase, tick period
        for (int sel = 0; sel < 2; sel++)
            for (int pi = 0; pi < 2; pi++)
                for (int d = 0; d < 4; d++)
                    for (int w = 0; w < 4; w++)
                        for (int s = 0; s < 4; s++)
                            run_seq(d, w, s, sel, (pi == 0) ? 1 : 3, 1'b0, "R6 sweep");

        // R1 R4: delay high byte in use
        run_seq(16'h0102, 3, 1, 0, 1, 1'b0, "R1 delay-hi");
        // R1 R5: width high byte in use
        run_seq(0, 16'h0100, 2, 1, 1, 1'b0, "R1 width-hi");
        // R7: second trigger accepted-edge lands on edge 8 while pulse is running
        run_seq(2, 4, 0, 0, 1, 1'b1, "R7 retrigger");
        run_seq(2, 4, 2, 1, 1, 1'b1, "R7 retrigger");

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule